// File: doc/BRIEF.md
# I2C Register-Access Slave

This block sits on a two-wire serial bus as a slave and lets an external master read and write a bank of 128 byte-wide registers held inside it. Both bus lines are resynchronised into a fast system clock, and every bus event (START, STOP, clock edges) is found by edge detection on the synchronised copies. The block drives the data line only by pulling it low through an open-drain enable. It never holds the clock low.

A write transfer carries, in order, the device address with the write direction, a sub-address byte and any number of data bytes. The slave acknowledges every byte that is addressed to it. A read transfer first sets the register pointer with a write-addressed sub-address phase. The master then issues a repeated START and the device address with the read direction, and the slave returns bytes until the master declines to acknowledge. The most significant bit of the sub-address selects whether the pointer steps after each data byte. The lowest bit of the device address comes from a strap input.

Top module: `serial_regport_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. `bus_busy` is 1 from a START until the next STOP and is 0 otherwise.
- R2: The slave accepts the 7-bit address 0011000b when `addr_strap` is 0 and 0011001b when it is 1. The address is sent MSB first and is followed by a direction bit (1 = read, 0 = write). The slave acknowledges a match by holding SDA low during the high phase of the ninth clock.
- R3: When the address does not match, the slave does not acknowledge and does not drive SDA for any later byte until the next START.
- R4: After an acknowledged write address, the next byte is the sub-address. Bits 6:0 select the register, and the slave acknowledges this byte.
- R5: Each data byte written after the sub-address is stored in the selected register and is acknowledged.
- R6: When sub-address bit 7 is 1, the register pointer steps by one after each data byte, whether read or written. It wraps from 7Fh to 00h.
- R7: When sub-address bit 7 is 0, every data byte of the transfer uses the same register.
- R8: A read returns the register at the pointer set by the preceding sub-address phase. It follows a repeated START and a read-direction address, and the data is sent MSB first.
- R9: A master acknowledge after a read byte makes the slave send the next byte. A master not-acknowledge ends the read, and the slave leaves SDA released.
- R10: A STOP in the middle of a byte returns the slave to idle without storing anything. A START in the middle of a byte restarts address reception.
- R11: The slave drives SDA only while the bus is busy. It changes its SDA drive only while the synchronised SCL is low or on a START or STOP.
- R12: After reset the bus is idle, SDA is released and every register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 1 | Strap giving the lowest bit of the device address |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| bus_busy | output | 1 | 1 between a START and a STOP |

## Verification
The hardest situations to reach are the aborted ones. These are a STOP or a repeated START arriving part-way through a byte, and a not-acknowledge that must leave the line released while the slave still holds a pending pointer. The bench's bus master can emit a chosen number of bits of a byte and then a START or STOP at once. It then reads the affected registers back through normal transfers, so the bench can show that nothing was stored and that address reception restarted cleanly.

// File: rtl/regport_i2c_pkg.sv
package regport_i2c_pkg;
   localparam int BYTE_W = 8;
   localparam int DEV_AW = 7;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK
   } xfer_state_t;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("line_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bus_events.sv
module bus_events #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev,
   output logic busy
);
   logic scl_d, sda_d;

   line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy <= 1'b0;
      else if (start_ev) busy <= 1'b1;
      else if (stop_ev)  busy <= 1'b0;
   end
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
   parameter int AW = 7,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          we,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   cells[g] <= '0;
            else if (we && (addr == AW'(g)))              cells[g] <= wdata;
         end
      end
   endgenerate

   assign rdata = cells[addr];
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
   import regport_i2c_pkg::*;
#(
   parameter int               REG_AW  = 7,
   parameter logic [DEV_AW-2:0] ADDR_HI = 6'b001100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_strap,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   output logic [REG_AW-1:0] rf_addr,
   output logic [BYTE_W-1:0] rf_wdata,
   output logic              rf_we,
   input  logic [BYTE_W-1:0] rf_rdata,
   output logic              sda_drive
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   xfer_state_t       state;
   logic [CNT_W-1:0]  cnt;
   logic              full;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic [REG_AW-1:0] ptr;
   logic              auto_inc;
   logic              rd_dir;
   logic [REG_AW-1:0] step;

   assign step     = {{(REG_AW-1){1'b0}}, auto_inc};
   assign rf_addr  = ptr;
   assign rf_wdata = rx_sh;
   assign rf_we    = (state == ST_WDATA) && scl_fall && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         full      <= 1'b0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         ptr       <= '0;
         auto_inc  <= 1'b0;
         rd_dir    <= 1'b0;
         sda_drive <= 1'b0;
      end else if (start_ev) begin
         state     <= ST_ADDR;
         cnt       <= '0;
         full      <= 1'b0;
         sda_drive <= 1'b0;
      end else if (stop_ev) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         full      <= 1'b0;
         sda_drive <= 1'b0;
      end else begin
         case (state)
            ST_ADDR, ST_SUB, ST_WDATA: begin
               if (scl_rise && !full) begin
                  rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
                  if (cnt == LAST_BIT) full <= 1'b1;
                  else                 cnt  <= cnt + 1'b1;
               end else if (scl_fall && full) begin
                  full <= 1'b0;
                  cnt  <= '0;
                  if (state == ST_ADDR) begin
                     if (rx_sh[BYTE_W-1:1] == {ADDR_HI, addr_strap}) begin
                        rd_dir    <= rx_sh[0];
                        sda_drive <= 1'b1;
                        state     <= ST_ADDR_ACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_SUB) begin
                     ptr       <= rx_sh[REG_AW-1:0];
                     auto_inc  <= rx_sh[BYTE_W-1];
                     sda_drive <= 1'b1;
                     state     <= ST_SUB_ACK;
                  end else begin
                     ptr       <= ptr + step;
                     sda_drive <= 1'b1;
                     state     <= ST_WDATA_ACK;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  if (rd_dir) begin
                     tx_sh     <= rf_rdata;
                     sda_drive <= ~rf_rdata[BYTE_W-1];
                     cnt       <= '0;
                     state     <= ST_RDATA;
                  end else begin
                     sda_drive <= 1'b0;
                     state     <= ST_SUB;
                  end
               end
            end
            ST_SUB_ACK, ST_WDATA_ACK: begin
               if (scl_fall) begin
                  sda_drive <= 1'b0;
                  state     <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (scl_fall) begin
                  if (cnt == LAST_BIT) begin
                     sda_drive <= 1'b0;
                     cnt       <= '0;
                     ptr       <= ptr + step;
                     state     <= ST_RDATA_ACK;
                  end else begin
                     tx_sh     <= {tx_sh[BYTE_W-2:0], 1'b0};
                     sda_drive <= ~tx_sh[BYTE_W-2];
                     cnt       <= cnt + 1'b1;
                  end
               end
            end
            ST_RDATA_ACK: begin
               if (scl_rise && sda_s) begin
                  state <= ST_IDLE;
               end else if (scl_fall) begin
                  tx_sh     <= rf_rdata;
                  sda_drive <= ~rf_rdata[BYTE_W-1];
                  state     <= ST_RDATA;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/serial_regport_slave.sv
module serial_regport_slave
   import regport_i2c_pkg::*;
#(
   parameter int                REG_AW      = 7,
   parameter logic [DEV_AW-2:0] ADDR_HI     = 6'b001100,
   parameter int                SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic addr_strap,
   output logic sda_drive_low,
   output logic bus_busy
);
   generate
      if (REG_AW < 1 || REG_AW > BYTE_W - 1) begin : g_bad_aw
         $error("REG_AW must fit in the sub-address field");
      end
   endgenerate

   logic              scl_sync, sda_sync;
   logic              scl_rise, scl_fall, start_ev, stop_ev;
   logic [REG_AW-1:0] rf_addr;
   logic [BYTE_W-1:0] rf_wdata, rf_rdata;
   logic              rf_we;

   bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
      .busy(bus_busy));

   xfer_fsm #(.REG_AW(REG_AW), .ADDR_HI(ADDR_HI)) u_fsm (
      .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .sda_s(sda_sync),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
      .stop_ev(stop_ev), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
      .rf_we(rf_we), .rf_rdata(rf_rdata), .sda_drive(sda_drive_low));

   reg_bank #(.AW(REG_AW), .DW(BYTE_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .addr(rf_addr), .wdata(rf_wdata),
      .we(rf_we), .rdata(rf_rdata));
endmodule

// File: rtl/regport_i2c_chk.sv
module regport_i2c_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic sda_s,
   input logic busy,
   input logic sda_drive
);
   // R1
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(scl_s) && !$past(sda_s)));

   // R1
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(scl_s) && $past(sda_s)));

   // R11
   drive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_drive);

   // R11
   drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive) |-> (!$past(scl_s) || ($past(sda_s) != $past(sda_s, 2))));
endmodule

bind serial_regport_slave regport_i2c_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_sync), .sda_s(sda_sync),
   .busy(bus_busy), .sda_drive(sda_drive_low));

// File: tb/test_serial_regport_slave.sv
module test_serial_regport_slave;
   localparam int HP = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic strap = 1'b0;
   logic sda_drive_low, bus_busy;
   logic sda_line;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit exp_busy = 1'b0;
   bit prev_busy = 1'b0;
   int settle = 0;
   logic [7:0] model [128];

   assign sda_line = m_sda & ~sda_drive_low;

   always #2 clk = ~clk;

   serial_regport_slave i_serial_regport_slave (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
      .addr_strap(strap), .sda_drive_low(sda_drive_low), .bus_busy(bus_busy));

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R1: busy compared every clock once the bus has settled
   always @(negedge clk) begin
      cycles++;
      if (exp_busy != prev_busy) begin
         prev_busy = exp_busy;
         settle = 0;
      end else if (settle < 20) settle++;
      if (rst_n && settle >= 6) chk("R1 bus_busy", bus_busy, exp_busy);
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         report();
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(HP);
      m_scl = 1'b1; tick(HP);
      m_sda = 1'b0; exp_busy = 1'b1; tick(HP);
      m_scl = 1'b0; tick(HP);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(HP);
      m_scl = 1'b1; tick(HP);
      m_sda = 1'b1; exp_busy = 1'b0; tick(2 * HP);
   endtask

   task automatic clk_bit(input bit b, output bit seen);
      m_sda = b; tick(HP);
      m_scl = 1'b1; tick(HP / 2);
      seen = sda_line; tick(HP / 2);
      m_scl = 1'b0;
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      bit s;
      for (int i = 7; i > 7 - n; i--) clk_bit(v[i], s);
   endtask

   task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string tag);
      bit s;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
      clk_bit(1'b1, s);
      chk(tag, s, exp_ack ? 0 : 1);
   endtask

   task automatic recv_byte(input logic [7:0] exp, input bit nack, input string tag);
      bit s;
      logic [7:0] got;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         got[i] = s;
      end
      chk(tag, got, exp);
      clk_bit(nack, s);
   endtask

   function automatic logic [7:0] dev(input bit rd);
      return {6'b001100, strap, rd};
   endfunction

   task automatic write_regs(input logic [7:0] sub, input int n,
                             input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input string tag);
      logic [6:0] p;
      logic [7:0] bytes [3];
      bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
      p = sub[6:0];
      bus_start();
      send_byte(dev(1'b0), 1'b1, {tag, " R2 addr ack"});
      send_byte(sub, 1'b1, {tag, " R4 sub ack"});
      for (int k = 0; k < n; k++) begin
         send_byte(bytes[k], 1'b1, {tag, " R5 data ack"});
         model[p] = bytes[k];
         if (sub[7]) p = p + 7'd1;
      end
      bus_stop();
   endtask

   task automatic read_regs(input logic [7:0] sub, input int n, input string tag);
      logic [6:0] p;
      p = sub[6:0];
      bus_start();
      send_byte(dev(1'b0), 1'b1, {tag, " R2 addr ack"});
      send_byte(sub, 1'b1, {tag, " R4 sub ack"});
      bus_start();
      send_byte(dev(1'b1), 1'b1, {tag, " R8 read addr ack"});
      for (int k = 0; k < n; k++) begin
         recv_byte(model[p], k == n - 1, {tag, " R8 read data"});
         if (sub[7]) p = p + 7'd1;
      end
      tick(HP);
      chk({tag, " R9 released after nack"}, sda_drive_low, 0);
      bus_stop();
   endtask

   initial begin
      for (int i = 0; i < 128; i++) model[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // R12 reset state
      chk("R12 busy after reset", bus_busy, 0);
      chk("R12 sda released after reset", sda_drive_low, 0);
      read_regs(8'hC0, 2, "R12 reset contents");

      // R5 R6 burst write with stepping, then read back
      write_regs(8'h85, 3, 8'hA1, 8'hB2, 8'hC3, "R6 burst write");
      read_regs(8'h85, 3, "R6 burst read");

      // R7 fixed pointer
      write_regs(8'h10, 3, 8'h11, 8'h22, 8'h33, "R7 fixed write");
      read_regs(8'h10, 2, "R7 fixed read");
      read_regs(8'h91, 1, "R7 neighbour untouched");

      // R6 wrap from 7Fh to 00h
      write_regs(8'hFE, 3, 8'h5A, 8'h6B, 8'h7C, "R6 wrap write");
      read_regs(8'hFF, 2, "R6 wrap read");

      // R3 wrong address while strap is low
      bus_start();
      send_byte(8'h32, 1'b0, "R3 foreign addr no ack");
      send_byte(8'h05, 1'b0, "R3 later byte ignored");
      send_byte(8'hFF, 1'b0, "R3 data ignored");
      chk("R3 sda released", sda_drive_low, 0);
      bus_stop();
      read_regs(8'h85, 1, "R3 contents unchanged");

      // R2 strap high moves the address
      strap = 1'b1;
      bus_start();
      send_byte(8'h30, 1'b0, "R2 low-strap addr refused");
      bus_stop();
      write_regs(8'h20, 1, 8'h99, 8'h00, 8'h00, "R2 strap high");
      read_regs(8'h20, 1, "R2 strap high read");

      // R10 STOP in the middle of a data byte
      bus_start();
      send_byte(dev(1'b0), 1'b1, "R10 addr ack");
      send_byte(8'h20, 1'b1, "R10 sub ack");
      send_bits(8'h44, 4);
      bus_stop();
      chk("R10 busy low after stop", bus_busy, 0);
      read_regs(8'h20, 1, "R10 nothing stored");

      // R10 START in the middle of the address and of a data byte
      bus_start();
      send_bits(8'h55, 3);
      bus_start();
      send_byte(dev(1'b0), 1'b1, "R10 addr after restart");
      send_byte(8'h21, 1'b1, "R10 sub ack");
      send_bits(8'hEE, 3);
      bus_start();
      send_byte(dev(1'b1), 1'b1, "R10 read addr after restart");
      recv_byte(model[7'h21], 1'b1, "R10 read pointer kept");
      bus_stop();

      // R9 master ack chain across several bytes
      read_regs(8'h85, 3, "R9 ack chain");

      report();
      $finish;
   end
endmodule